// File: doc/BRIEF.md
# Synchronous Burst SRAM with Burst Address Generator

This block is a single-clock synchronous RAM that serves four-beat bursts. An access starts when an address strobe is seen at a rising clock edge. There are two strobes: one for the processor side and one for the cache-controller side. At that edge the block captures the address and the three chip-select inputs. A 2-bit beat counter then forms the remaining three addresses of the 4-word block, and it moves on only at edges where the advance input is low.

The burst order is chosen at the start of each burst and held for the whole burst. It is either linear, wrapping inside the aligned 4-word block, or interleaved, where the start offset is XOR-ed with the beat number. Writes use four byte lanes, each with its own enable, qualified by a byte-write enable. A global write stores the whole word.

Read data follows a flow-through timing pattern. The word at the current burst address appears in the cycle after the strobe edge, and each later advance brings a new word one cycle later. This gives 2-1-1-1 timing. Read data reflects any write made at the latest edge. Output enable gates the data output combinationally.

Top module: `sync_burst_sram`

## Requirements
- R1: A burst is loaded at a rising edge when `adsc_n` is low, or when `adsp_n` is low together with `ce1_n` low. The load captures `addr` and resets the beat number to 0. The burst is selected only if `ce1_n`=0, `ce2`=1 and `ce3_n`=0 at that edge; otherwise the block is deselected.
- R2: When `ce1_n` is high at an edge, a low `adsp_n` has no effect: the address, the beat number, the selection state and the output are unchanged.
- R3: A low `adsc_n` restarts a burst at beat 0 even in the middle of a burst, and it overrides a low `adv_n` at the same edge.
- R4: With no load at an edge, the beat number increments (mod 4) only if the block is selected and `adv_n` is low. Otherwise the current address is held.
- R5: When `mode` was 0 at the load edge, the low two address bits are (start + beat) mod 4. The upper bits stay those of the captured address.
- R6: When `mode` was 1 at the load edge, the low two address bits are start XOR beat.
- R7: At a non-load edge while selected, `gw_n` low writes all four bytes of `din` to the current address, whatever `bwe_n` and `bw_n` are.
- R8: With `gw_n` high and `bwe_n` low, only lanes whose `bw_n` bit is low are written. Bit i selects `din[8i+7:8i]`. If both `gw_n` and `bwe_n` are high the cycle is a read. No write happens at a load edge or while deselected.
- R9: After each edge, while selected and with `oe_n` low, `dout` equals the stored word at the current burst address, including any write made at that edge. The first word is therefore present in the cycle after the strobe edge.
- R10: `oe_n` high forces `dout` to 0 without waiting for a clock edge. `dout` is also 0 while deselected.
- R11: After a synchronous `rst`, the block is deselected and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address sampled at a load edge |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Primary chip select, active low; also qualifies `adsp_n` |
| ce2 | input | 1 | Expansion chip select, active high |
| ce3_n | input | 1 | Expansion chip select, active low |
| mode | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| gw_n | input | 1 | Whole-word write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| din | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Output enable, active low, combinational |
| dout | output | LANES*LANE_W | Read data, 0 when disabled |

## Verification
Two collisions are provoked on purpose. In the first, a write lands at the same edge that selects the same word for reading: the bench stalls `adv_n` while writing, so the read port and the write port address one word. In the second, a controller strobe arrives while `adv_n` is low in mid-burst, so the restart and the advance compete. A behavioural model updated at every rising edge predicts the current address and the stored words. The bench compares `dout` with that model at every falling edge. A stale word, or a beat that steps when it should restart, shows up as a mismatch naming R9 or R3.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // Low two address bits of a beat, given the start offset and the order
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/sbs_addr_ctrl.sv
module sbs_addr_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              mode,
  output logic              load,
  output logic              active,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] rd_addr
);
  import sbs_pkg::*;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  logic              act_d, ilv_q, ilv_d;
  logic              sel;

  assign load = !adsc_n || (!adsp_n && !ce1_n);
  assign sel  = !ce1_n && ce2 && !ce3_n;

  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    act_d  = active;
    ilv_d  = ilv_q;
    if (load) begin
      base_d = addr;
      beat_d = 2'd0;
      act_d  = sel;
      ilv_d  = mode;
    end else if (active && !adv_n) begin
      beat_d = beat_q + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= 2'd0;
      active <= 1'b0;
      ilv_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      beat_q <= beat_d;
      active <= act_d;
      ilv_q  <= ilv_d;
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], beat_q, ilv_q)};
  assign rd_addr  = {base_d[ADDR_W-1:2], burst_lo(base_d[1:0], beat_d, ilv_d)};

  p_load_zero_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat_q == 2'd0 && base_q == $past(addr)));
  p_adv_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && active && !adv_n) |=> (beat_q == $past(beat_q) + 2'd1));
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> ($stable(beat_q) && $stable(base_q)));
endmodule

// File: rtl/sbs_write_dec.sv
module sbs_write_dec #(
  parameter int LANES = 4
) (
  input  logic             en,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] lane_we
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = en && (!gw_n || (!bwe_n && !bw_n[i]));
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q, byp_d;
    logic              byp_q;

    always_ff @(posedge clk) begin
      if (we[i]) mem[wr_addr] <= wdata[i*LANE_W +: LANE_W];
      rd_q  <= mem[rd_addr];
      byp_d <= wdata[i*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rst) byp_q <= 1'b0;
      else     byp_q <= we[i] && (wr_addr == rd_addr);
    end

    assign rdata[i*LANE_W +: LANE_W] = byp_q ? byp_d : rd_q;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    mode,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] dout
);
  localparam int DATA_W = LANES * LANE_W;

  logic              load, active;
  logic [ADDR_W-1:0] cur_addr, rd_addr;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] arr_q;

  sbs_addr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .mode(mode),
    .load(load), .active(active), .cur_addr(cur_addr), .rd_addr(rd_addr)
  );

  sbs_write_dec #(.LANES(LANES)) u_wdec (
    .en(active && !load), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .lane_we(lane_we)
  );

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .rst(rst), .we(lane_we), .wr_addr(cur_addr),
    .rd_addr(rd_addr), .wdata(din), .rdata(arr_q)
  );

  assign dout = (!oe_n && active) ? arr_q : '0;

  p_idle_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
    !active |-> (lane_we == '0));
  p_load_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
    load |-> (lane_we == '0));
  p_gw_full_r7: assert property (@(posedge clk) disable iff (rst)
    (active && !load && !gw_n) |-> (&lane_we));
endmodule

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1, mode = 1'b0;
  logic gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [3:0] bw_n = 4'hF;
  logic [31:0] din = '0;
  logic [31:0] dout;

  sync_burst_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(8)) dut (
    .clk(clk), .rst(rst), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .mode(mode),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .din(din), .oe_n(oe_n),
    .dout(dout)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  string req = "R9";
  bit chk_en = 1'b0;

  logic [31:0] ref_mem [DEPTH];
  int r_base = 0, r_beat = 0;
  bit r_act = 1'b0, r_ilv = 1'b0;

  function automatic int cur_a();
    int lo;
    if (r_ilv) lo = (r_base & 3) ^ r_beat;
    else       lo = ((r_base & 3) + r_beat) % 4;
    return (r_base & ~3) | lo;
  endfunction

  function automatic logic [31:0] exp_out();
    return (r_act && !oe_n) ? ref_mem[cur_a()] : 32'h0;
  endfunction

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dout=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  // One clock: the model follows the edge, then dout is compared at the falling edge
  task automatic tick();
    bit ld;
    int c;
    @(posedge clk);
    if (rst) begin
      r_act = 1'b0; r_beat = 0; r_base = 0; r_ilv = 1'b0;
    end else begin
      ld = !adsc_n || (!adsp_n && !ce1_n);
      c  = cur_a();
      if (!ld && r_act) begin
        if (!gw_n) ref_mem[c] = din;
        else if (!bwe_n)
          for (int l = 0; l < 4; l++)
            if (!bw_n[l]) ref_mem[c][l*8 +: 8] = din[l*8 +: 8];
      end
      if (ld) begin
        r_base = int'(addr); r_beat = 0;
        r_act = !ce1_n && ce2 && !ce3_n; r_ilv = mode;
      end else if (r_act && !adv_n) begin
        r_beat = (r_beat + 1) % 4;
      end
    end
    @(negedge clk);
    if (chk_en) check(req, dout, exp_out());
  endtask

  task automatic start(bit use_c, int a, bit m);
    addr = AW'(a); mode = m;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    if (use_c) adsc_n = 1'b0; else adsp_n = 1'b0;
    tick();
    adsc_n = 1'b1; adsp_n = 1'b1;
  endtask

  task automatic beat(bit adv, bit g, bit be, logic [3:0] bw, logic [31:0] d);
    adv_n = !adv; gw_n = !g; bwe_n = !be; bw_n = bw; din = d;
    tick();
    adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    // R11: reset state
    tick(); tick();
    check("R11", dout, 32'h0);
    rst = 1'b0;
    tick();
    check("R11", dout, 32'h0);

    // Fill memory with whole-word writes (R7)
    for (int b = 0; b < DEPTH / 4; b++) begin
      start(1'b1, b * 4, 1'b0);
      for (int k = 0; k < 4; k++)
        beat(1'b1, 1'b1, 1'b0, 4'hF, 32'hA500_0000 ^ ((b * 4 + k) * 32'h0103_0507));
    end
    chk_en = 1'b1;

    // R5: linear bursts, all four start offsets, processor strobe
    req = "R5";
    for (int s = 0; s < 4; s++) begin
      start(1'b0, 8 + s, 1'b0);
      for (int k = 0; k < 4; k++) beat(1'b1, 1'b0, 1'b0, 4'hF, '0);
    end
    // R6: interleaved bursts, all offsets, controller strobe
    req = "R6";
    for (int s = 0; s < 4; s++) begin
      start(1'b1, 20 + s, 1'b1);
      for (int k = 0; k < 4; k++) beat(1'b1, 1'b0, 1'b0, 4'hF, '0);
    end

    // R8: partial byte writes, then read back
    req = "R8";
    start(1'b1, 32, 1'b0);
    beat(1'b1, 1'b0, 1'b1, 4'b1110, 32'h1111_1111);
    beat(1'b1, 1'b0, 1'b1, 4'b0101, 32'h2222_2222);
    beat(1'b1, 1'b0, 1'b0, 4'b0000, 32'h3333_3333);
    beat(1'b1, 1'b0, 1'b1, 4'b1111, 32'h4444_4444);
    start(1'b0, 32, 1'b0);
    for (int k = 0; k < 4; k++) beat(1'b1, 1'b0, 1'b0, 4'hF, '0);
    // R7: global write overrides lane enables
    req = "R7";
    start(1'b1, 36, 1'b1);
    beat(1'b0, 1'b1, 1'b1, 4'b1111, 32'hCAFE_F00D);
    start(1'b1, 36, 1'b1);
    beat(1'b0, 1'b0, 1'b0, 4'hF, '0);

    // R9: write while stalled: read and write hit one word
    req = "R9";
    start(1'b1, 41, 1'b0);
    beat(1'b0, 1'b0, 1'b1, 4'b0011, 32'h5A5A_5A5A);
    beat(1'b0, 1'b1, 1'b0, 4'hF, 32'h1234_5678);
    beat(1'b1, 1'b1, 1'b0, 4'hF, 32'h9ABC_DEF0);
    beat(1'b1, 1'b0, 1'b0, 4'hF, '0);
    // R4: stalls between advances
    req = "R4";
    start(1'b0, 46, 1'b1);
    for (int k = 0; k < 4; k++) begin
      beat(1'b0, 1'b0, 1'b0, 4'hF, '0);
      beat(1'b1, 1'b0, 1'b0, 4'hF, '0);
    end

    // R2: processor strobe with ce1_n high is ignored mid-burst
    req = "R2";
    start(1'b0, 50, 1'b0);
    beat(1'b1, 1'b0, 1'b0, 4'hF, '0);
    addr = AW'(12); ce1_n = 1'b1; adsp_n = 1'b0;
    tick();
    adsp_n = 1'b1;
    beat(1'b1, 1'b0, 1'b0, 4'hF, '0);

    // R3: controller strobe restarts mid-burst while adv_n low
    req = "R3";
    start(1'b1, 54, 1'b1);
    beat(1'b1, 1'b0, 1'b0, 4'hF, '0);
    addr = AW'(59); adsc_n = 1'b0; adv_n = 1'b0; mode = 1'b0;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    tick();
    adsc_n = 1'b1;
    tick(); tick();
    adv_n = 1'b1;

    // R1: deselect through ce2, write ignored, output zero
    req = "R1";
    addr = AW'(60); adsc_n = 1'b0; ce2 = 1'b0;
    tick();
    adsc_n = 1'b1;
    beat(1'b1, 1'b1, 1'b0, 4'hF, 32'hDEAD_BEEF);
    check("R10", dout, 32'h0);
    start(1'b1, 60, 1'b0);
    beat(1'b1, 1'b0, 1'b0, 4'hF, '0);

    // R10: oe_n acts without a clock edge
    oe_n = 1'b1;
    #1;
    check("R10", dout, 32'h0);
    oe_n = 1'b0;
    #1;
    check("R10", dout, ref_mem[cur_a()]);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule